// File: doc/BRIEF.md
# Ethernet MAC Receive Status and Transmit Pause Monitor

This block produces the 32-bit status word of a multi-channel Ethernet MAC. Each cycle it compares the free-buffer counts of eight receive channels with two kinds of limit. Each channel has its own flow threshold. All channels share one quality-of-service (QoS) low threshold. The results of these comparisons become the receive flow-active and QoS-active flags.

The block also records receive DMA host errors. The first error sets an error code, which stays set until hardware reset, and a channel number, which the host clears by reading the status word. A pending host-error interrupt is raised while the error is held.

On the transmit side, a gate decides whether a new frame may start. While a received pause period is in force, only pause frames may start. A frame that has already started always runs until its end-of-frame. The gigabit and full-duplex link-mode inputs are copied into the status word.

Two small state machines carry the block's state:

- **Error capture.** State `ERR_CLEAR` moves to `ERR_HELD` on a host error with a nonzero code (transition *capture*). `ERR_HELD` has no way out except reset. Inside it, a host read clears the channel field (transition *read-clear*).
- **Transmit gate.** State `TXG_IDLE` moves to `TXG_SEND` when a start request is granted (transition *grant*). `TXG_SEND` returns to `TXG_IDLE` on end-of-frame (transition *frame-end*).

Top module: `emac_status_mon`

## Requirements
- R1: After reset the status word reads 0, `host_err_irq` is 0 and `tx_busy` is 0.
- R2: Bit 1 of the status word is 1 one cycle after at least one channel has a free-buffer count less than or equal to its own flow threshold. Otherwise bit 1 is 0.
- R3: Bit 2 of the status word is 1 one cycle after a cycle in which `qos_en` is 1 and at least one channel has a count less than or equal to `qos_low_thr`. Otherwise bit 2 is 0.
- R4: In state `ERR_CLEAR`, a cycle with `herr_valid` high and a nonzero `herr_code` does three things. It stores the code in bits 15:12 and the channel in bits 10:8, and it raises `host_err_irq` from the next cycle. Code 2h means the start-of-packet buffer was not owned. Code 4h means a zero buffer pointer. A report with code 0 is ignored.
- R5: Once an error is held, the code and `host_err_irq` stay unchanged until reset. Later error reports change neither the code nor the channel.
- R6: A cycle with `stat_rd` high while an error is held sets bits 10:8 to 0 from the next cycle. The code is unchanged.
- R7: Bit 0 of the status word equals `pause_in` from the previous cycle.
- R8: In `TXG_IDLE`, `tx_grant` equals `tx_sof_req AND (NOT bit0 OR tx_is_pause)` in the same cycle. `tx_grant` is 0 in `TXG_SEND`.
- R9: After a grant, `tx_busy` is 1 from the next cycle until the cycle after `tx_eof`. This holds whatever `pause_in` does.
- R10: Bit 4 equals `link_gig` and bit 3 equals `link_fdx` of the previous cycle. Bits 31:16, 11 and 7:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_cnt_flat | input | NUM_CH*CNT_W | Free-buffer count per channel; channel n in bits [n*CNT_W +: CNT_W] |
| flow_thr_flat | input | NUM_CH*CNT_W | Flow threshold per channel, same packing |
| qos_low_thr | input | CNT_W | Shared QoS low threshold |
| qos_en | input | 1 | Receive QoS enable |
| herr_valid | input | 1 | Host error report strobe |
| herr_code | input | 4 | Host error code (2h, 4h) |
| herr_chan | input | 3 | Channel of the reported error |
| stat_rd | input | 1 | Host read strobe for the status word |
| pause_in | input | 1 | A received pause period is being honoured |
| link_gig | input | 1 | Gigabit link mode |
| link_fdx | input | 1 | Full-duplex link mode |
| tx_sof_req | input | 1 | Request to start a transmit frame |
| tx_is_pause | input | 1 | The requested frame is a pause frame |
| tx_eof | input | 1 | The current transmit frame ends this cycle |
| stat_word | output | 32 | Status word |
| host_err_irq | output | 1 | Host-error interrupt pending |
| tx_grant | output | 1 | Start of the requested frame is allowed |
| tx_busy | output | 1 | A granted frame is in progress |

## Verification
The bench drives counts and thresholds that sit exactly on the limit. A comparison written as strict less-than would drop the flag whenever a count equals its threshold. A mix-up between per-channel and shared thresholds would also show at these points.

It sends a second error after the first one. A design that overwrites on a new error would change the code or bring the channel back after a read. It also sends a read together with a new error, and a code-0 report.

Pause is raised in the middle of a frame. A gate that aborted the frame would drop `tx_busy` early, and a gate that ignored the pause-frame qualifier would block pause frames.

// File: rtl/emac_stat_pkg.sv
package emac_stat_pkg;
    localparam int CODE_W = 4;
    localparam int CHAN_W = 3;
    localparam int STAT_W = 32;

    localparam int TXFLOW_BIT = 0;
    localparam int RXFLOW_BIT = 1;
    localparam int QOS_BIT    = 2;
    localparam int FDX_BIT    = 3;
    localparam int GIG_BIT    = 4;
    localparam int CHAN_LSB   = 8;
    localparam int CODE_LSB   = 12;

    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_HELD  = 1'b1
    } err_state_e;

    typedef enum logic {
        TXG_IDLE = 1'b0,
        TXG_SEND = 1'b1
    } txg_state_e;
endpackage

// File: rtl/emac_flow_cmp.sv
module emac_flow_cmp #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*CNT_W-1:0] free_cnt_flat,
    input  logic [NUM_CH*CNT_W-1:0] flow_thr_flat,
    input  logic [CNT_W-1:0]        qos_low_thr,
    input  logic                    qos_en,
    output logic                    rx_flow_q,
    output logic                    qos_act_q
);
    logic [NUM_CH-1:0] flow_hit;
    logic [NUM_CH-1:0] qos_hit;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] thr;
        assign cnt         = free_cnt_flat[ch*CNT_W +: CNT_W];
        assign thr         = flow_thr_flat[ch*CNT_W +: CNT_W];
        assign flow_hit[ch] = (cnt <= thr);
        assign qos_hit[ch]  = (cnt <= qos_low_thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flow_q <= 1'b0;
            qos_act_q <= 1'b0;
        end else begin
            rx_flow_q <= |flow_hit;
            qos_act_q <= qos_en && (|qos_hit);
        end
    end
endmodule

// File: rtl/emac_herr_capture.sv
module emac_herr_capture
    import emac_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              herr_valid,
    input  logic [CODE_W-1:0] herr_code,
    input  logic [CHAN_W-1:0] herr_chan,
    input  logic              stat_rd,
    output logic [CODE_W-1:0] err_code_q,
    output logic [CHAN_W-1:0] err_chan_q,
    output logic              err_held
);
    err_state_e state_q, state_d;
    logic       capture;

    assign capture = herr_valid && (herr_code != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAR: if (capture) state_d = ERR_HELD;
            ERR_HELD:  state_d = ERR_HELD;
            default:   state_d = ERR_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_CLEAR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_code_q <= '0;
            err_chan_q <= '0;
        end else begin
            unique case (state_q)
                ERR_CLEAR: begin
                    if (capture) begin
                        err_code_q <= herr_code;
                        err_chan_q <= herr_chan;
                    end
                end
                ERR_HELD: begin
                    if (stat_rd) err_chan_q <= '0;
                end
                default: begin
                    err_code_q <= '0;
                    err_chan_q <= '0;
                end
            endcase
        end
    end

    assign err_held = (state_q == ERR_HELD);
endmodule

// File: rtl/emac_tx_gate.sv
module emac_tx_gate
    import emac_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pause_flag,
    input  logic sof_req,
    input  logic is_pause,
    input  logic eof,
    output logic grant,
    output logic busy
);
    txg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TXG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        unique case (state_q)
            TXG_IDLE: begin
                if (sof_req && (!pause_flag || is_pause)) begin
                    grant   = 1'b1;
                    state_d = TXG_SEND;
                end
            end
            TXG_SEND: begin
                if (eof) state_d = TXG_IDLE;
            end
            default: state_d = TXG_IDLE;
        endcase
    end

    assign busy = (state_q == TXG_SEND);
endmodule

// File: rtl/emac_status_mon.sv
module emac_status_mon
    import emac_stat_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*CNT_W-1:0] free_cnt_flat,
    input  logic [NUM_CH*CNT_W-1:0] flow_thr_flat,
    input  logic [CNT_W-1:0]        qos_low_thr,
    input  logic                    qos_en,
    input  logic                    herr_valid,
    input  logic [3:0]              herr_code,
    input  logic [2:0]              herr_chan,
    input  logic                    stat_rd,
    input  logic                    pause_in,
    input  logic                    link_gig,
    input  logic                    link_fdx,
    input  logic                    tx_sof_req,
    input  logic                    tx_is_pause,
    input  logic                    tx_eof,
    output logic [31:0]             stat_word,
    output logic                    host_err_irq,
    output logic                    tx_grant,
    output logic                    tx_busy
);
    logic              rx_flow_q;
    logic              qos_act_q;
    logic              txflow_q;
    logic              gig_q;
    logic              fdx_q;
    logic [CODE_W-1:0] err_code_q;
    logic [CHAN_W-1:0] err_chan_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txflow_q <= 1'b0;
            gig_q    <= 1'b0;
            fdx_q    <= 1'b0;
        end else begin
            txflow_q <= pause_in;
            gig_q    <= link_gig;
            fdx_q    <= link_fdx;
        end
    end

    emac_flow_cmp #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) u_flow (
        .clk           (clk),
        .rst_n         (rst_n),
        .free_cnt_flat (free_cnt_flat),
        .flow_thr_flat (flow_thr_flat),
        .qos_low_thr   (qos_low_thr),
        .qos_en        (qos_en),
        .rx_flow_q     (rx_flow_q),
        .qos_act_q     (qos_act_q)
    );

    emac_herr_capture u_herr (
        .clk        (clk),
        .rst_n      (rst_n),
        .herr_valid (herr_valid),
        .herr_code  (herr_code),
        .herr_chan  (herr_chan),
        .stat_rd    (stat_rd),
        .err_code_q (err_code_q),
        .err_chan_q (err_chan_q),
        .err_held   (host_err_irq)
    );

    emac_tx_gate u_txg (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_flag (txflow_q),
        .sof_req    (tx_sof_req),
        .is_pause   (tx_is_pause),
        .eof        (tx_eof),
        .grant      (tx_grant),
        .busy       (tx_busy)
    );

    always_comb begin
        stat_word = '0;
        stat_word[TXFLOW_BIT] = txflow_q;
        stat_word[RXFLOW_BIT] = rx_flow_q;
        stat_word[QOS_BIT]    = qos_act_q;
        stat_word[FDX_BIT]    = fdx_q;
        stat_word[GIG_BIT]    = gig_q;
        stat_word[CHAN_LSB +: CHAN_W] = err_chan_q;
        stat_word[CODE_LSB +: CODE_W] = err_code_q;
    end
endmodule

// File: rtl/emac_status_mon_chk.sv
module emac_status_mon_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] stat_word,
    input logic        host_err_irq,
    input logic        stat_rd,
    input logic        qos_en,
    input logic        tx_sof_req,
    input logic        tx_is_pause,
    input logic        tx_eof,
    input logic        tx_grant,
    input logic        tx_busy
);
    // R4
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_irq |-> (stat_word[15:12] != 4'd0));

    // R5
    code_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_irq |=> (host_err_irq && stat_word[15:12] == $past(stat_word[15:12])));

    // R6
    chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_err_irq && stat_rd) |=> (stat_word[10:8] == 3'd0));

    // R3
    qos_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qos_en |=> !stat_word[2]);

    // R8
    pause_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[0] && tx_sof_req && !tx_is_pause) |-> !tx_grant);

    // R9
    inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_eof) |=> tx_busy);

    // R9
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> tx_busy);

    // R8
    no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_grant);
endmodule

bind emac_status_mon emac_status_mon_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_word    (stat_word),
    .host_err_irq (host_err_irq),
    .stat_rd      (stat_rd),
    .qos_en       (qos_en),
    .tx_sof_req   (tx_sof_req),
    .tx_is_pause  (tx_is_pause),
    .tx_eof       (tx_eof),
    .tx_grant     (tx_grant),
    .tx_busy      (tx_busy)
);

// File: tb/emac_status_mon_tb.sv
module emac_status_mon_tb;
    localparam int NUM_CH = 8;
    localparam int CNT_W  = 8;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [NUM_CH*CNT_W-1:0] free_cnt_flat;
    logic [NUM_CH*CNT_W-1:0] flow_thr_flat;
    logic [CNT_W-1:0]        qos_low_thr;
    logic                    qos_en;
    logic                    herr_valid;
    logic [3:0]              herr_code;
    logic [2:0]              herr_chan;
    logic                    stat_rd;
    logic                    pause_in;
    logic                    link_gig;
    logic                    link_fdx;
    logic                    tx_sof_req;
    logic                    tx_is_pause;
    logic                    tx_eof;
    logic [31:0]             stat_word;
    logic                    host_err_irq;
    logic                    tx_grant;
    logic                    tx_busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    bit       m_held;
    bit [3:0] m_code;
    bit [2:0] m_chan;
    bit       m_busy;
    bit       m_txflow;
    bit       m_rxflow;
    bit       m_qos;
    bit       m_gig;
    bit       m_fdx;

    always #5 clk = ~clk;

    emac_status_mon #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .free_cnt_flat (free_cnt_flat), .flow_thr_flat (flow_thr_flat),
        .qos_low_thr (qos_low_thr), .qos_en (qos_en),
        .herr_valid (herr_valid), .herr_code (herr_code), .herr_chan (herr_chan),
        .stat_rd (stat_rd), .pause_in (pause_in),
        .link_gig (link_gig), .link_fdx (link_fdx),
        .tx_sof_req (tx_sof_req), .tx_is_pause (tx_is_pause), .tx_eof (tx_eof),
        .stat_word (stat_word), .host_err_irq (host_err_irq),
        .tx_grant (tx_grant), .tx_busy (tx_busy)
    );

    function automatic bit any_flow_hit();
        for (int i = 0; i < NUM_CH; i++)
            if (free_cnt_flat[i*CNT_W +: CNT_W] <= flow_thr_flat[i*CNT_W +: CNT_W]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit any_qos_hit();
        for (int i = 0; i < NUM_CH; i++)
            if (free_cnt_flat[i*CNT_W +: CNT_W] <= qos_low_thr) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_grant();
        return !m_busy && tx_sof_req && (!m_txflow || tx_is_pause);
    endfunction

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[0] = m_txflow; w[1] = m_rxflow; w[2] = m_qos;
        w[3] = m_fdx;    w[4] = m_gig;
        w[10:8] = m_chan; w[15:12] = m_code;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        free_cnt_flat = '1; flow_thr_flat = '0; qos_low_thr = '0; qos_en = 1'b0;
        herr_valid = 1'b0; herr_code = '0; herr_chan = '0; stat_rd = 1'b0;
        pause_in = 1'b0; link_gig = 1'b0; link_fdx = 1'b0;
        tx_sof_req = 1'b0; tx_is_pause = 1'b0; tx_eof = 1'b0;
    endtask

    task automatic model_reset();
        m_held = 0; m_code = 0; m_chan = 0; m_busy = 0; m_txflow = 0;
        m_rxflow = 0; m_qos = 0; m_gig = 0; m_fdx = 0;
    endtask

    // inputs already set (at a negedge); checks grant, advances one edge, checks outputs
    task automatic step();
        bit g;
        #1;
        g = exp_grant();
        check("R8 grant", {31'd0, tx_grant}, {31'd0, g});
        // next model state
        m_rxflow = any_flow_hit();
        m_qos    = qos_en && any_qos_hit();
        if (!m_held && herr_valid && herr_code != 0) begin
            m_held = 1; m_code = herr_code; m_chan = herr_chan;
        end else if (m_held && stat_rd) begin
            m_chan = 0;
        end
        if (!m_busy && g) m_busy = 1;
        else if (m_busy && tx_eof) m_busy = 0;
        m_txflow = pause_in; m_gig = link_gig; m_fdx = link_fdx;
        @(negedge clk);
        check("R2 rx flow",     {31'd0, stat_word[1]},  {31'd0, m_rxflow});
        check("R3 qos",         {31'd0, stat_word[2]},  {31'd0, m_qos});
        check("R7 tx flow",     {31'd0, stat_word[0]},  {31'd0, m_txflow});
        check("R10 link/rsvd",  stat_word & 32'hFFFF_08F8, exp_word() & 32'hFFFF_08F8);
        check("R4 R5 code/irq", {27'd0, host_err_irq, stat_word[15:12]}, {27'd0, m_held, m_code});
        check("R6 chan",        {29'd0, stat_word[10:8]}, {29'd0, m_chan});
        check("R9 busy",        {31'd0, tx_busy}, {31'd0, m_busy});
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R1 reset word", stat_word, 32'd0);
        check("R1 reset irq/busy", {30'd0, host_err_irq, tx_busy}, 32'd0);
    endtask

    task automatic randomize_inputs(input int err_pct);
        for (int i = 0; i < NUM_CH; i++) begin
            free_cnt_flat[i*CNT_W +: CNT_W] = CNT_W'($urandom_range(0, 255));
            flow_thr_flat[i*CNT_W +: CNT_W] = CNT_W'($urandom_range(0, 40));
        end
        qos_low_thr = CNT_W'($urandom_range(0, 60));
        qos_en      = ($urandom_range(0, 3) != 0);
        herr_valid  = ($urandom_range(0, 99) < err_pct);
        case ($urandom_range(0, 2))
            0: herr_code = 4'h0;
            1: herr_code = 4'h2;
            default: herr_code = 4'h4;
        endcase
        herr_chan   = 3'($urandom_range(0, 7));
        stat_rd     = ($urandom_range(0, 7) == 0);
        pause_in    = ($urandom_range(0, 2) == 0);
        link_gig    = 1'($urandom_range(0, 1));
        link_fdx    = 1'($urandom_range(0, 1));
        tx_sof_req  = 1'($urandom_range(0, 1));
        tx_is_pause = ($urandom_range(0, 3) == 0);
        tx_eof      = ($urandom_range(0, 3) == 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 1'b0;
        model_reset();
        do_reset();

        // Directed R2: count equal to own threshold on channel 5 only
        @(negedge clk);
        idle_inputs();
        free_cnt_flat[5*CNT_W +: CNT_W] = 8'd17;
        flow_thr_flat[5*CNT_W +: CNT_W] = 8'd17;
        step();
        // one above threshold everywhere: flag drops
        free_cnt_flat[5*CNT_W +: CNT_W] = 8'd18;
        step();

        // Directed R3: count equal to shared threshold, enabled then disabled
        free_cnt_flat[2*CNT_W +: CNT_W] = 8'd9;
        qos_low_thr = 8'd9; qos_en = 1'b1;
        step();
        qos_en = 1'b0;
        step();

        // Directed R4/R5/R6: code 0 ignored, first error captured, later ignored, read clears
        idle_inputs();
        herr_valid = 1'b1; herr_code = 4'h0; herr_chan = 3'd6;
        step();
        herr_code = 4'h2; herr_chan = 3'd5;
        step();
        herr_code = 4'h4; herr_chan = 3'd3;
        step();
        herr_valid = 1'b0; stat_rd = 1'b1;
        step();
        stat_rd = 1'b0; herr_valid = 1'b1; herr_code = 4'h4; herr_chan = 3'd7;
        step();
        do_reset();

        // Directed R8/R9: pause blocks data frame, lets pause frame, mid-frame pause keeps busy
        @(negedge clk);
        idle_inputs();
        pause_in = 1'b1;
        step();
        tx_sof_req = 1'b1; tx_is_pause = 1'b0;
        step();
        tx_is_pause = 1'b1;
        step();
        tx_sof_req = 1'b0;
        step();
        tx_eof = 1'b1; pause_in = 1'b0;
        step();
        tx_eof = 1'b0; tx_sof_req = 1'b1; tx_is_pause = 1'b0;
        step();
        tx_sof_req = 1'b0; pause_in = 1'b1;
        step(); step();
        tx_eof = 1'b1;
        step();

        // Constrained random phases with resets between them
        for (int ph = 0; ph < 4; ph++) begin
            for (int n = 0; n < 600; n++) begin
                randomize_inputs(ph == 0 ? 2 : 10);
                step();
            end
            do_reset();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule